// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between an internal single-word request port and an external 64K x 16 asynchronous static RAM. Each accepted request becomes one complete read or write on the memory pins. Chip enable, write enable and output enable are active low. There is one strobe for each byte lane, and the block controls the direction of the 16-bit data bus. Every interval on the memory side is counted in clock cycles. Each count is derived from a clock-period parameter and the memory's nanosecond minimums, rounded up, with a floor of one cycle.

Only one request is in flight at a time. `req_ready` is high only while the controller is idle. A read ends with a one-cycle `rsp_valid` pulse that carries the masked read word. A write ends with the same pulse once the write strobe has risen.

Between transactions chip enable goes high for at least one cycle. This satisfies the rule that a change between read and write must be marked by a chip-enable toggle or an address change.

With the default 20 ns clock, the derived counts are:
- access: 5 cycles
- bus release before driving: 2 cycles
- write strobe: 3 cycles

Top module: `sram_lane_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `mem_ce_n`, `mem_we_n`, `mem_oe_n`, `mem_lb_n` and `mem_ub_n` are high, `mem_dq_oe` is low, `rsp_valid` is low and `req_ready` is high. Reset acts at once, even in the middle of a write.
- R2: `req_ready` is high only while idle. It is low in the cycle after a request is accepted and stays low until the controller returns to idle.
- R3: A read holds `mem_ce_n` and `mem_oe_n` low and `mem_we_n` high for ceil(100/CLK_NS) cycles. The data bus is sampled on the last of those cycles. `rsp_valid` pulses for one cycle in the next cycle, so the read latency from acceptance is ceil(100/CLK_NS)+1 cycles.
- R4: `req_be` bit 0 selects bits 7:0 (`mem_lb_n`) and bit 1 selects bits 15:8 (`mem_ub_n`). On a read, a lane whose bit is clear keeps its strobe high and returns zero in `rsp_rdata`.
- R5: A write first spends ceil(40/CLK_NS) cycles with `mem_ce_n` low, `mem_oe_n` high, `mem_we_n` high and the bus undriven. It then drives the write data with `mem_we_n` low. It then spends one cycle with `mem_we_n` high and the data still driven, and `rsp_valid` pulses in that cycle.
- R6: On a write, a lane whose `req_be` bit is clear keeps its strobe high, so the memory keeps that byte.
- R7: A write with `req_be` = 00 never drives `mem_we_n` low and responds ceil(40/CLK_NS)+1 cycles after acceptance.
- R8: `mem_addr` changes only in a cycle where `mem_we_n` is high and was high in the cycle before.
- R9: `mem_dq_oe` is never high while `mem_oe_n` is low.
- R10: `mem_ce_n` is high in the cycle after every `rsp_valid` pulse.
- R11: The write strobe lasts max(ceil(50/CLK_NS), ceil(40/CLK_NS), ceil(100/CLK_NS) minus the turnaround count) cycles. This is at least 3 cycles at 20 ns, and the address is held for at least 100 ns before the write ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken on this edge |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte lane select, bit 0 = low byte |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | 16 | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Low byte strobe, active low |
| mem_ub_n | output | 1 | High byte strobe, active low |
| mem_dq_o | output | 16 | Data toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | 16 | Data from the memory |

## Verification
The memory model returns a poison word until output enable has been low for the full access count. A controller that samples one cycle early therefore returns wrong data rather than merely being late.

Byte-masked writes and the 00-mask write are followed by full-word reads. A lane that was written when it should have been kept shows up as a changed byte. An empty write that still pulses the strobe shows up in the strobe-fall count.

Monitors flag several timing faults:
- an address that moves while the write strobe is low;
- the bus driven while output enable is low;
- a write strobe shorter than three cycles;
- chip enable staying low across the gap between transactions.

A reset dropped in the middle of a write strobe has to return every strobe high at once.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACC,
    ST_RD_DONE,
    ST_WR_TURN,
    ST_WR_PULSE,
    ST_WR_HOLD,
    ST_GAP
  } ctl_state_e;

  // Nanoseconds to whole clock cycles, rounded up, never below one.
  function automatic int unsigned ns2cyc(int unsigned ns, int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_wait_cnt.sv
module sram_wait_cnt #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

  // R3 / R5: a running count steps down by exactly one per cycle.
  p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sram_lane_mask.sv
module sram_lane_mask #(
  parameter int unsigned DW = 16,
  localparam int unsigned LANES = DW / 8
) (
  input  logic             lane_act,
  input  logic [LANES-1:0] be,
  input  logic [DW-1:0]    rd_raw,
  output logic [LANES-1:0] lane_n,
  output logic [DW-1:0]    rd_masked
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_n[i]           = !(lane_act && be[i]);
    assign rd_masked[i*8 +: 8] = be[i] ? rd_raw[i*8 +: 8] : 8'h00;
  end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CLK_NS  = 20,
  parameter int unsigned AW      = 16,
  parameter int unsigned DW      = 16,
  parameter int unsigned ACC_NS  = 100,
  parameter int unsigned WP_NS   = 50,
  parameter int unsigned DS_NS   = 40,
  parameter int unsigned REL_NS  = 40,
  parameter int unsigned AVW_NS  = 100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [1:0]    req_be,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic          mem_lb_n,
  output logic          mem_ub_n,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_i
);

  localparam int unsigned T_ACC  = ns2cyc(ACC_NS, CLK_NS);
  localparam int unsigned T_TURN = ns2cyc(REL_NS, CLK_NS);
  localparam int unsigned T_AVW  = ns2cyc(AVW_NS, CLK_NS);
  localparam int unsigned T_AVWR = (T_AVW > T_TURN) ? T_AVW - T_TURN : 1;
  localparam int unsigned T_WP   = umax(umax(ns2cyc(WP_NS, CLK_NS),
                                             ns2cyc(DS_NS, CLK_NS)), T_AVWR);
  localparam int unsigned T_MAX  = umax(umax(T_ACC, T_TURN), T_WP);
  localparam int unsigned CW     = $clog2(T_MAX + 1);
  localparam logic [CW-1:0] ACC_V  = CW'(T_ACC - 1);
  localparam logic [CW-1:0] TURN_V = CW'(T_TURN - 1);
  localparam logic [CW-1:0] WP_V   = CW'(T_WP - 1);

  ctl_state_e    state_q, state_d;
  logic          accept, rd_take, cnt_load, cnt_done;
  logic [CW-1:0] cnt_val;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q, rd_masked;
  logic [1:0]    be_q, lane_n;
  logic          rd_phase, wr_phase;

  sram_wait_cnt #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val), .done(cnt_done)
  );

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    accept   = 1'b0;
    rd_take  = 1'b0;
    cnt_load = 1'b0;
    cnt_val  = '0;
    unique case (state_q)
      ST_IDLE: if (req_valid) begin
        accept   = 1'b1;
        cnt_load = 1'b1;
        if (req_we) begin state_d = ST_WR_TURN; cnt_val = TURN_V; end
        else        begin state_d = ST_RD_ACC;  cnt_val = ACC_V;  end
      end
      ST_RD_ACC:  if (cnt_done) begin rd_take = 1'b1; state_d = ST_RD_DONE; end
      ST_RD_DONE: state_d = ST_GAP;
      ST_WR_TURN: if (cnt_done) begin
        if (|be_q) begin state_d = ST_WR_PULSE; cnt_load = 1'b1; cnt_val = WP_V; end
        else       state_d = ST_WR_HOLD;
      end
      ST_WR_PULSE: if (cnt_done) state_d = ST_WR_HOLD;
      ST_WR_HOLD:  state_d = ST_GAP;
      ST_GAP:      state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  // State and captured request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      be_q    <= req_be;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (rd_take) rdata_q <= rd_masked;
  end

  assign rd_phase = (state_q == ST_RD_ACC);
  assign wr_phase = (state_q == ST_WR_TURN) || (state_q == ST_WR_PULSE) ||
                    (state_q == ST_WR_HOLD);

  sram_lane_mask #(.DW(DW)) u_lane (
    .lane_act(rd_phase || wr_phase), .be(be_q), .rd_raw(mem_dq_i),
    .lane_n(lane_n), .rd_masked(rd_masked)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign rsp_valid = (state_q == ST_RD_DONE) || (state_q == ST_WR_HOLD);
  assign rsp_rdata = rdata_q;
  assign mem_addr  = addr_q;
  assign mem_ce_n  = !(rd_phase || wr_phase);
  assign mem_oe_n  = !rd_phase;
  assign mem_we_n  = (state_q != ST_WR_PULSE);
  assign mem_lb_n  = lane_n[0];
  assign mem_ub_n  = lane_n[1];
  assign mem_dq_o  = wdata_q;
  assign mem_dq_oe = (state_q == ST_WR_PULSE) || (state_q == ST_WR_HOLD);

  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  p_rsp_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  p_we_fall_turn_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> (!$past(mem_ce_n) && !$past(mem_dq_oe) && $past(mem_oe_n)));
  p_addr_we_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mem_addr) |-> (mem_we_n && $past(mem_we_n)));
  p_no_contend_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);
  p_ce_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> mem_ce_n);

endmodule

// File: tb/sram_lane_ctrl_tb.sv
module sram_lane_ctrl_tb;

  localparam int EXP_RD_LAT  = 6;   // 5 access cycles + response
  localparam int EXP_WR_LAT  = 6;   // 2 turnaround + 3 strobe + hold
  localparam int EXP_NOP_LAT = 3;   // 2 turnaround + hold
  localparam int ACC_CYC     = 5;
  localparam int WP_MIN      = 3;

  typedef struct packed {
    logic        we;
    logic [7:0]  a;
    logic [15:0] d;
    logic [1:0]  be;
    logic [15:0] exp;
  } vec_t;

  localparam vec_t VEC [0:10] = '{
    '{1'b1, 8'h10, 16'h1234, 2'b11, 16'h0000},
    '{1'b1, 8'h11, 16'hABCD, 2'b11, 16'h0000},
    '{1'b0, 8'h10, 16'h0000, 2'b11, 16'h1234},
    '{1'b1, 8'h10, 16'h5A77, 2'b01, 16'h0000},
    '{1'b0, 8'h10, 16'h0000, 2'b11, 16'h1277},
    '{1'b1, 8'h11, 16'h9988, 2'b10, 16'h0000},
    '{1'b0, 8'h11, 16'h0000, 2'b11, 16'h99CD},
    '{1'b1, 8'h11, 16'h0000, 2'b00, 16'h0000},
    '{1'b0, 8'h11, 16'h0000, 2'b11, 16'h99CD},
    '{1'b0, 8'h11, 16'h0000, 2'b01, 16'h00CD},
    '{1'b0, 8'h10, 16'h0000, 2'b10, 16'h1200}
  };

  logic        clk, rst_n;
  logic        req_valid, req_ready, req_we;
  logic [15:0] req_addr, req_wdata;
  logic [1:0]  req_be;
  logic        rsp_valid;
  logic [15:0] rsp_rdata, mem_addr, mem_dq_o, mem_dq_i;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe;

  int checks = 0, fails = 0;
  int we_falls = 0, mon_err_r8 = 0, mon_err_r9 = 0, mon_err_r10 = 0, mon_err_r11 = 0;
  bit finished = 0;

  logic [15:0] mem [256];
  int          acc_cnt;

  sram_lane_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_dq_o(mem_dq_o),
    .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Memory model: data valid only after the full access time.
  always @(posedge clk) begin
    if (!mem_ce_n && !mem_oe_n) acc_cnt <= acc_cnt + 1;
    else                        acc_cnt <= 0;
  end
  assign mem_dq_i = (!mem_ce_n && !mem_oe_n && mem_we_n && acc_cnt >= ACC_CYC - 1)
                    ? mem[mem_addr[7:0]] : 16'hBAD0;

  always @(posedge mem_we_n) begin
    if (!mem_ce_n && mem_dq_oe) begin
      if (!mem_lb_n) mem[mem_addr[7:0]][7:0]  = mem_dq_o[7:0];
      if (!mem_ub_n) mem[mem_addr[7:0]][15:8] = mem_dq_o[15:8];
    end
  end

  // Protocol monitors, sampled on the falling edge.
  logic [15:0] pv_addr;
  logic        pv_we, pv_rsp;
  int          we_len;
  always @(negedge clk) begin
    if (!rst_n) begin
      pv_we = 1'b1; pv_rsp = 1'b0; we_len = 0; pv_addr = mem_addr;
    end else begin
      if (mem_addr != pv_addr && (!mem_we_n || !pv_we)) mon_err_r8++;
      if (mem_dq_oe && !mem_oe_n) mon_err_r9++;
      if (pv_rsp && !mem_ce_n) mon_err_r10++;
      if (!mem_we_n) we_len++;
      if (pv_we && !mem_we_n) we_falls++;
      if (!pv_we && mem_we_n) begin
        if (we_len < WP_MIN) mon_err_r11++;
        we_len = 0;
      end
      pv_we = mem_we_n; pv_rsp = rsp_valid; pv_addr = mem_addr;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xact(input vec_t v, output logic [15:0] rd, output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_we = v.we; req_addr = {8'h00, v.a};
    req_wdata = v.d;  req_be = v.be;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    chk(req_ready == 1'b0, "R2 ready low while busy", {15'd0, req_ready}, 16'd0);
    while (!rsp_valid && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    rd = rsp_rdata;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic chk_idle_pins(input string tag);
    chk(mem_ce_n && mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n && !mem_dq_oe && !rsp_valid,
        tag, {10'd0, mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe},
        16'b111110);
  endtask

  initial begin
    #4_000_000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 16'd0, 16'd1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    int lat, falls0;
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    rst_n = 1'b0; req_valid = 1'b0; req_we = 1'b0;
    req_addr = '0; req_wdata = '0; req_be = '0;
    #5;
    chk_idle_pins("R1 pins in reset");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle_pins("R1 pins after reset");
    chk(req_ready == 1'b1, "R1 ready after reset", {15'd0, req_ready}, 16'd1);

    // Vector table
    for (int i = 0; i <= 10; i++) begin
      falls0 = we_falls;
      xact(VEC[i], rd, lat);
      if (!VEC[i].we) begin
        chk(rd == VEC[i].exp, "R3/R4/R6 read data", rd, VEC[i].exp);   // R4 R6
        chk(lat == EXP_RD_LAT, "R3 read latency", 16'(lat), 16'(EXP_RD_LAT));
      end else if (VEC[i].be == 2'b00) begin
        chk(lat == EXP_NOP_LAT, "R7 empty write latency", 16'(lat), 16'(EXP_NOP_LAT));
        chk(we_falls == falls0, "R7 no strobe", 16'(we_falls - falls0), 16'd0);
      end else begin
        chk(lat == EXP_WR_LAT, "R5 write latency", 16'(lat), 16'(EXP_WR_LAT));
        chk(we_falls == falls0 + 1, "R5 one strobe", 16'(we_falls - falls0), 16'd1);
      end
    end

    // Directed: reset in the middle of a write strobe (R1)
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; req_addr = 16'h0030;
    req_wdata = 16'h7777; req_be = 2'b11;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(mem_we_n == 1'b0, "R5 strobe low after turnaround", {15'd0, mem_we_n}, 16'd0);
    rst_n = 1'b0;
    #1;
    chk_idle_pins("R1 async reset mid-write");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after mid-write reset", {15'd0, req_ready}, 16'd1);
    xact('{1'b0, 8'h11, 16'h0000, 2'b11, 16'h99CD}, rd, lat);
    chk(rd == 16'h99CD, "R3 read after reset", rd, 16'h99CD);

    chk(mon_err_r8 == 0, "R8 address moved with strobe low", 16'(mon_err_r8), 16'd0);
    chk(mon_err_r9 == 0, "R9 bus contention", 16'(mon_err_r9), 16'd0);
    chk(mon_err_r10 == 0, "R10 chip enable gap", 16'(mon_err_r10), 16'd0);
    chk(mon_err_r11 == 0, "R11 short strobe", 16'(mon_err_r11), 16'd0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule